// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns a load-multiple or store-multiple request into the series of word addresses and register indices that the memory side must move. A request names a base address, a register mask, an addressing mode and whether the base is to be rewritten. The sequencer walks the mask from the lowest-numbered register upward and issues one beat per memory access. Each beat carries one 32-bit word, or two words when the address sits on a doubleword boundary and at least two registers are still pending.

After the final beat it reports, for one cycle, the updated base value and whether that value should be written back. A request is taken with a one-cycle `start` pulse while the block is idle. The memory side paces the beats with `ready`. Register file access and data movement belong to the neighbouring logic.

Top module: `bts_seq`

## Requirements
- R1: With N set bits in the mask and base B, the first beat address is B for mode 0 (increment, access after), B+4 for mode 1 (increment, access before), B-4N+4 for mode 2 (decrement, access after) and B-4N for mode 3 (decrement, access before), modulo 2^32.
- R2: Registers are issued in ascending index order, so the lowest-numbered register always sits at the lowest address. Each accepted beat advances the address by 8 after a paired beat and by 4 after a single beat.
- R3: A beat is paired (`beat_pair`=1, second index on `beat_reg1`) exactly when its address has bits [2:0] equal to zero and at least two registers remain. Otherwise it carries one word.
- R4: When the operation completes, `wb_value` holds B+4N for modes 0 and 1 and B-4N for modes 2 and 3. `wb_write` equals the latched write-back enable in the `done` cycle and is 0 at all other times.
- R5: A request with an empty mask issues no beat, keeps `busy` low, raises `done` in the next cycle, and reports `wb_value` equal to B.
- R6: While `beat_valid` is high and `ready` is low, the beat outputs hold their values in the next cycle.
- R7: `done` is high for exactly one cycle, the cycle after the last beat is accepted, and `busy` and `beat_valid` are low in that cycle.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The running operation keeps its beats and its write-back value.
- R9: After a synchronous reset, `busy`, `done`, `beat_valid` and `wb_write` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse, taken only while idle |
| base_addr | input | ADDR_W | Base address B |
| reg_list | input | REG_COUNT | Register mask, bit i selects register i |
| mode | input | 2 | Addressing mode 0..3 as in R1 |
| wb_en | input | 1 | Write-back enable for this request |
| ready | input | 1 | Memory side accepts the current beat |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| beat_valid | output | 1 | A beat is being offered |
| beat_addr | output | ADDR_W | Word address of the beat |
| beat_reg0 | output | log2(REG_COUNT) | Register at beat_addr |
| beat_reg1 | output | log2(REG_COUNT) | Register at beat_addr+4 when paired, else 0 |
| beat_pair | output | 1 | Beat carries two words |
| wb_value | output | ADDR_W | Updated base, valid with done |
| wb_write | output | 1 | Write the updated base back |

## Verification
The bench builds the sequencer with REG_COUNT=8 and ADDR_W=32. This makes the sweep over every mask exhaustive: all 256 masks, under all four modes, from four bases. One base is doubleword aligned, one is offset by a word, and two sit next to the top and bottom of the address space, so address wrap-around is covered. Every pairing situation, every count from empty to full, and the odd and even tails of a run are all reached. Random `ready` gaps exercise stalls on every kind of beat, and stray `start` pulses injected mid-run test that busy requests are refused.

// File: rtl/bts_pkg.sv
// Shared types for the block transfer address sequencer.
// Assumes addresses are byte addresses of 32-bit words.
package bts_pkg;

    // Addressing modes; bit 1 selects decrement, bit 0 the "before" variant.
    typedef enum logic [1:0] {
        XM_INC_AFTER  = 2'd0,
        XM_INC_BEFORE = 2'd1,
        XM_DEC_AFTER  = 2'd2,
        XM_DEC_BEFORE = 2'd3
    } xfer_mode_e;

    localparam int WORD_BYTES  = 4;
    localparam int DWORD_BYTES = 8;

endpackage

// File: rtl/bts_popcount.sv
// Counts the set bits of a register mask.
// Assumes W is small enough for an unrolled adder chain.
module bts_popcount #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits,
    output logic [CW-1:0] count
);

    // Sum every mask bit.
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(bits[i]);
        end
    end

endmodule

// File: rtl/bts_origin.sv
// Works out, from base, mask and mode, the first beat address and the
// write-back value. Purely combinational; the result is captured by the top.
// Assumes the base is word aligned and arithmetic wraps modulo 2^ADDR_W.
module bts_origin
    import bts_pkg::*;
#(
    parameter int REG_COUNT = 16,
    parameter int ADDR_W    = 32
) (
    input  logic [ADDR_W-1:0]    base,
    input  logic [REG_COUNT-1:0] mask,
    input  logic [1:0]           mode,
    output logic [ADDR_W-1:0]    first_addr,
    output logic [ADDR_W-1:0]    wb_next
);

    localparam int CW = $clog2(REG_COUNT + 1);

    logic [CW-1:0]     nregs;
    logic [ADDR_W-1:0] span;

    bts_popcount #(.W(REG_COUNT), .CW(CW)) u_count (
        .bits  (mask),
        .count (nregs)
    );

    // Byte span of the whole transfer: four bytes per selected register.
    assign span = {{(ADDR_W - CW - 2){1'b0}}, nregs, 2'b00};

    // Starting address so that the lowest register lands lowest.
    always_comb begin
        unique case (xfer_mode_e'(mode))
            XM_INC_AFTER:  first_addr = base;
            XM_INC_BEFORE: first_addr = base + ADDR_W'(WORD_BYTES);
            XM_DEC_AFTER:  first_addr = base - span + ADDR_W'(WORD_BYTES);
            default:       first_addr = base - span;
        endcase
    end

    // Updated base: moves by the full span in the mode's direction.
    assign wb_next = mode[1] ? (base - span) : (base + span);

endmodule

// File: rtl/bts_lowest.sv
// Finds the lowest set bit of a mask and returns the mask with it cleared.
// Assumes idx is meaningful only when found is high.
module bts_lowest #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  rest
);

    // Scan from the top so the last hit is the lowest index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    // Clear the lowest set bit.
    assign rest = bits & (bits - W'(1));

endmodule

// File: rtl/bts_seq.sv
// Block transfer address sequencer. Accepts a request while idle, then
// offers one beat per cycle, one or two registers wide, advancing on ready.
// Pulses done after the last beat with the updated base.
// Assumes a word-aligned base and a memory side that honours beat_pair.
module bts_seq
    import bts_pkg::*;
#(
    parameter int REG_COUNT = 16,
    parameter int ADDR_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [ADDR_W-1:0]            base_addr,
    input  logic [REG_COUNT-1:0]         reg_list,
    input  logic [1:0]                   mode,
    input  logic                         wb_en,
    input  logic                         ready,
    output logic                         busy,
    output logic                         done,
    output logic                         beat_valid,
    output logic [ADDR_W-1:0]            beat_addr,
    output logic [$clog2(REG_COUNT)-1:0] beat_reg0,
    output logic [$clog2(REG_COUNT)-1:0] beat_reg1,
    output logic                         beat_pair,
    output logic [ADDR_W-1:0]            wb_value,
    output logic                         wb_write
);

    localparam int IW = $clog2(REG_COUNT);

    logic                 busy_q, done_q, wbe_q;
    logic [REG_COUNT-1:0] rem_q;
    logic [ADDR_W-1:0]    cur_q, wb_q;

    logic [ADDR_W-1:0]    first_addr, wb_next;
    logic                 found0, found1;
    logic [IW-1:0]        idx0, idx1;
    logic [REG_COUNT-1:0] rest0, rest1;
    logic                 pair, last;

    bts_origin #(.REG_COUNT(REG_COUNT), .ADDR_W(ADDR_W)) u_origin (
        .base       (base_addr),
        .mask       (reg_list),
        .mode       (mode),
        .first_addr (first_addr),
        .wb_next    (wb_next)
    );

    bts_lowest #(.W(REG_COUNT), .IW(IW)) u_first (
        .bits  (rem_q),
        .found (found0),
        .idx   (idx0),
        .rest  (rest0)
    );

    bts_lowest #(.W(REG_COUNT), .IW(IW)) u_second (
        .bits  (rest0),
        .found (found1),
        .idx   (idx1),
        .rest  (rest1)
    );

    // Pair two registers only on a doubleword boundary with two pending.
    assign pair = busy_q && found0 && found1 && (cur_q[2:0] == 3'b000);
    // Last beat when nothing is left after this one.
    assign last = pair ? (rest1 == '0) : (rest0 == '0);

    // Request capture, beat advance and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            wbe_q  <= 1'b0;
            rem_q  <= '0;
            cur_q  <= '0;
            wb_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q && start) begin
                rem_q <= reg_list;
                cur_q <= first_addr;
                wb_q  <= wb_next;
                wbe_q <= wb_en;
                if (reg_list == '0) begin
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                end
            end else if (busy_q && ready) begin
                rem_q <= pair ? rest1 : rest0;
                cur_q <= cur_q + ADDR_W'(pair ? DWORD_BYTES : WORD_BYTES);
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy       = busy_q;
    assign beat_valid = busy_q;
    assign beat_addr  = cur_q;
    assign beat_reg0  = idx0;
    assign beat_reg1  = pair ? idx1 : '0;
    assign beat_pair  = pair;
    assign done       = done_q;
    assign wb_value   = wb_q;
    assign wb_write   = done_q && wbe_q;

    // R2: a paired beat carries two ascending registers.
    a_r2_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_pair |-> beat_reg1 > beat_reg0);

    // R2: an accepted beat moves the next address by the beat width.
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && ready |=> !beat_valid ||
            (beat_addr == $past(beat_addr) + ($past(beat_pair) ? ADDR_W'(8) : ADDR_W'(4))));

    // R6: a stalled beat is held.
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !ready |=> beat_valid && $stable(beat_addr)
            && $stable(beat_reg0) && $stable(beat_pair));

    // R7: busy ends only together with a done pulse.
    a_r7_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done && !beat_valid);

    // R7: done does not stretch unless a fresh empty request follows.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);

    // R5: an empty mask finishes next cycle without going busy.
    a_r5_empty: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (reg_list == '0) |=> done && !busy);

    // R4: write-back strobe only with done.
    a_r4_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_write |-> done);

endmodule

// File: tb/tb_bts_seq.sv
module tb_bts_seq;

    localparam int NR = 8;
    localparam int IW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   base_addr = '0;
    logic [NR-1:0] reg_list = '0;
    logic [1:0]    mode = '0;
    logic          wb_en = 1'b0;
    logic          ready = 1'b1;
    logic          busy, done, beat_valid, beat_pair, wb_write;
    logic [31:0]   beat_addr, wb_value;
    logic [IW-1:0] beat_reg0, beat_reg1;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    bts_seq #(.REG_COUNT(NR), .ADDR_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .reg_list(reg_list), .mode(mode), .wb_en(wb_en), .ready(ready),
        .busy(busy), .done(done), .beat_valid(beat_valid), .beat_addr(beat_addr),
        .beat_reg0(beat_reg0), .beat_reg1(beat_reg1), .beat_pair(beat_pair),
        .wb_value(wb_value), .wb_write(wb_write)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic next_ready();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0] | lfsr[1];
    endfunction

    task automatic run_op(input logic [1:0] m, input logic [31:0] b,
                          input logic [NR-1:0] l, input logic we, input logic inject);
        int regs[NR];
        int n = 0;
        int k = 0;
        int guard = 0;
        logic [31:0] a, wbv;
        logic stalled = 1'b0;
        logic injected = 1'b0;
        for (int i = 0; i < NR; i++) if (l[i]) begin regs[n] = i; n++; end
        case (m)
            2'd0: a = b;
            2'd1: a = b + 32'd4;
            2'd2: a = b - 32'(4 * n) + 32'd4;
            default: a = b - 32'(4 * n);
        endcase
        wbv = m[1] ? b - 32'(4 * n) : b + 32'(4 * n);
        @(negedge clk);
        start = 1'b1; base_addr = b; reg_list = l; mode = m; wb_en = we;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(done && !busy && !beat_valid, "R5", "empty done/busy", {done, busy, beat_valid}, 3'b100);
            chk(wb_value == b, "R5", "empty wb_value", wb_value, b);
            chk(wb_write == we, "R4", "empty wb_write", wb_write, we);
            return;
        end
        while (k < n && guard < 100) begin
            logic ep, rdy;
            string tg;
            guard++;
            ep = (a[2:0] == 3'b000) && (n - k >= 2);
            tg = stalled ? "R6" : (k == 0 ? "R1" : "R2");
            chk(beat_valid && busy && !done, "R7", "beat_valid/busy", {beat_valid, busy, done}, 3'b110);
            chk(beat_addr == a, tg, "beat_addr", beat_addr, a);
            chk(beat_pair == ep, "R3", "beat_pair", beat_pair, ep);
            chk(int'(beat_reg0) == regs[k], "R2", "beat_reg0", beat_reg0, regs[k]);
            if (ep) chk(int'(beat_reg1) == regs[k+1], "R3", "beat_reg1", beat_reg1, regs[k+1]);
            rdy = next_ready();
            ready = rdy;
            if (inject && k == 1 && !injected) begin
                injected = 1'b1;
                start = 1'b1; reg_list = ~l; mode = ~m; base_addr = b ^ 32'h100;
            end
            @(negedge clk);
            start = 1'b0;
            stalled = !rdy;
            if (rdy) begin
                k = k + (ep ? 2 : 1);
                a = a + (ep ? 32'd8 : 32'd4);
            end
        end
        ready = 1'b1;
        chk(done && !busy && !beat_valid, "R7", "end done/busy", {done, busy, beat_valid}, 3'b100);
        chk(wb_value == wbv, injected ? "R8" : "R4", "wb_value", wb_value, wbv);
        chk(wb_write == we, "R4", "wb_write", wb_write, we);
        @(negedge clk);
        chk(!done && !wb_write, "R7", "done pulse width", {done, wb_write}, 2'b00);
    endtask

    initial begin
        logic [31:0] bases[4] = '{32'h0000_0040, 32'h0000_0044, 32'hFFFF_FFF8, 32'h0000_0004};
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!busy && !done && !beat_valid && !wb_write, "R9", "reset outputs",
            {busy, done, beat_valid, wb_write}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !beat_valid, "R9", "after reset", {busy, done, beat_valid}, 3'b000);
        for (int m = 0; m < 4; m++) begin
            for (int bi = 0; bi < 4; bi++) begin
                for (int l = 0; l < (1 << NR); l++) begin
                    run_op(2'(m), bases[bi], NR'(l), 1'((l >> 1) ^ bi), (l % 5) == 3);
                end
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule